// File: doc/BRIEF.md
# Microcoded Opcode Fetch Sequencer

This block is the front of a microcoded 8-bit processor pipeline. It gives the decode stage new work on every clock. On an opcode cycle, decode reads the instruction register. On each following cycle, decode reads the microinstruction register, which holds one word of that opcode's microcode program. When a microinstruction carries the end marker, the sequencer reads the next opcode byte from memory, and the cycle after that is again an opcode cycle.

The microcode store sits outside the block. It is read combinationally through an address formed from the current opcode and a 3-bit step index. Reset is synchronous and active high. Reset does not read memory. Instead it places a break opcode (value 8'h00) in the instruction register, so the first cycle after reset is an opcode cycle for that break opcode, followed by its microcode.

Top module: `ucode_fetch_seq`

## Requirements
- R1: On the first cycle after `rst` falls, `sel_op_o`=1, `ir_o`=8'h00 and `mir_o`=0. While `rst` is held high, the same state is present from the second clock edge onward.
- R2: While `rst` is high, `ucode_addr_o`=0 and `mem_rd_o`=0. On the injected break-opcode cycle after reset, `mem_rd_o`=0, which means memory is not read.
- R3: On an opcode cycle (`sel_op_o`=1), `ucode_addr_o`={`ir_o`, 3'b000} and `mem_rd_o`=0. The next cycle is a microinstruction cycle whose `mir_o` equals the store word at that address.
- R4: On microinstruction cycles (`sel_op_o`=0), `mir_o` steps through the store words at {`ir_o`, step} for step = 0, 1, 2, ... in order. There is one word per cycle and no gap cycles.
- R5: Bit 0 of a microinstruction is its end marker. On a microinstruction cycle whose `mir_o[0]`=1, `mem_rd_o`=1. The next cycle is an opcode cycle with `ir_o` equal to the `mem_data_i` value present during that cycle.
- R6: `mem_data_i` is ignored on every cycle where `mem_rd_o`=0. `ir_o` changes only after a cycle with `mem_rd_o`=1.
- R7: The microinstruction fetched from step 7, the last slot, ends the instruction even when its bit 0 is clear. At most 8 microinstruction cycles follow an opcode cycle.
- R8: An end marker on the first microinstruction gives a two-cycle instruction. Several such instructions in a row run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_data_i | input | 8 | Opcode byte from memory. Sampled only when `mem_rd_o`=1 |
| ucode_data_i | input | 16 | Microcode store read data for `ucode_addr_o` |
| ucode_addr_o | output | 11 | Microcode store address {opcode, step} |
| mem_rd_o | output | 1 | Opcode read from memory this cycle |
| ir_o | output | 8 | Instruction register |
| mir_o | output | 16 | Microinstruction register |
| sel_op_o | output | 1 | 1: decode the opcode in `ir_o`. 0: decode `mir_o` |

## Verification
The bench runs instructions of one, six, seven and eight microinstructions. It checks every word and every phase flag on every cycle. A step counter that failed to clear on an opcode load would show up as shifted microcode words. An off-by-one in end handling would add or drop a cycle.

Non-zero noise is driven on `mem_data_i` in every cycle where no read is due. If the instruction register loaded at the wrong time, the wrong opcode would appear in it. The eight-word opcodes have no end marker at all. A design that did not force the end at the last slot would wrap and loop forever.

A reset applied in the middle of an instruction must return the block to the break opcode. During that reset the microcode address must be zero, and memory must not be read.

// File: rtl/ufs_pkg.sv
package ufs_pkg;
  localparam int OP_W    = 8;
  localparam int STEP_W  = 3;
  localparam int MI_W    = 16;
  localparam int END_BIT = 0;
  localparam int ADDR_W  = OP_W + STEP_W;
  localparam logic [OP_W-1:0] BRK_OP = '0;

  // microcode store address: opcode in the upper bits, step below
  function automatic logic [ADDR_W-1:0] ucode_addr(input logic [OP_W-1:0] op,
                                                   input logic [STEP_W-1:0] step);
    return {op, step};
  endfunction

  function automatic logic [STEP_W-1:0] step_next(input logic [STEP_W-1:0] step);
    return step + STEP_W'(1);
  endfunction

  function automatic logic is_last_slot(input logic [STEP_W-1:0] step);
    return step == {STEP_W{1'b1}};
  endfunction
endpackage

// File: rtl/ufs_step_ctr.sv
module ufs_step_ctr
  import ufs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic [STEP_W-1:0] step_o,
  output logic              last_o
);
  logic [STEP_W-1:0] step_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      step_q <= '0;
      last_q <= 1'b0;
    end else if (adv_i) begin
      last_q <= is_last_slot(step_q);
      step_q <= step_next(step_q);
    end
  end

  assign step_o = step_q;
  assign last_o = last_q;
endmodule

// File: rtl/ufs_phase_ctl.sv
module ufs_phase_ctl (
  input  logic clk,
  input  logic rst,
  input  logic end_i,
  output logic op_phase_o
);
  logic op_phase_q;

  always_ff @(posedge clk) begin
    if (rst)             op_phase_q <= 1'b1;
    else if (op_phase_q) op_phase_q <= 1'b0;
    else                 op_phase_q <= end_i;
  end

  assign op_phase_o = op_phase_q;
endmodule

// File: rtl/ufs_regs.sv
module ufs_regs
  import ufs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_ir_i,
  input  logic [OP_W-1:0] ir_d_i,
  input  logic            ld_mir_i,
  input  logic [MI_W-1:0] mir_d_i,
  output logic [OP_W-1:0] ir_o,
  output logic [MI_W-1:0] mir_o
);
  logic [OP_W-1:0] ir_q;
  logic [MI_W-1:0] mir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q  <= BRK_OP;
      mir_q <= '0;
    end else begin
      if (ld_ir_i)  ir_q  <= ir_d_i;
      if (ld_mir_i) mir_q <= mir_d_i;
    end
  end

  assign ir_o  = ir_q;
  assign mir_o = mir_q;
endmodule

// File: rtl/ucode_fetch_seq.sv
module ucode_fetch_seq
  import ufs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   mem_data_i,
  input  logic [MI_W-1:0]   ucode_data_i,
  output logic [ADDR_W-1:0] ucode_addr_o,
  output logic              mem_rd_o,
  output logic [OP_W-1:0]   ir_o,
  output logic [MI_W-1:0]   mir_o,
  output logic              sel_op_o
);
  logic              op_phase;
  logic [STEP_W-1:0] step;
  logic              last_slot;
  logic              mi_end;
  logic              ld_mir;

  // named internal events
  assign mi_end = !op_phase && (mir_o[END_BIT] || last_slot);
  assign ld_mir = !mi_end;

  ufs_phase_ctl u_phase (
    .clk        (clk),
    .rst        (rst),
    .end_i      (mi_end),
    .op_phase_o (op_phase)
  );

  ufs_step_ctr u_step (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (mi_end),
    .adv_i  (ld_mir),
    .step_o (step),
    .last_o (last_slot)
  );

  ufs_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .ld_ir_i  (mi_end),
    .ir_d_i   (mem_data_i),
    .ld_mir_i (ld_mir),
    .mir_d_i  (ucode_data_i),
    .ir_o     (ir_o),
    .mir_o    (mir_o)
  );

  assign ucode_addr_o = rst ? '0 : ucode_addr(ir_o, step);
  assign mem_rd_o     = !rst && mi_end;
  assign sel_op_o     = op_phase;
endmodule

// File: rtl/ucode_fetch_seq_chk.sv
module ucode_fetch_seq_chk
  import ufs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   mem_data_i,
  input logic [ADDR_W-1:0] ucode_addr_o,
  input logic              mem_rd_o,
  input logic [OP_W-1:0]   ir_o,
  input logic              sel_op_o
);
  localparam int RUN_W = STEP_W + 1;
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(2 ** STEP_W);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || sel_op_o)            run_q <= '0;
    else if (run_q != {RUN_W{1'b1}}) run_q <= run_q + RUN_W'(1);
  end

  AST_RST_QUIET: assert property (@(posedge clk) rst |-> (ucode_addr_o == '0 && !mem_rd_o)); // R2
  AST_RST_INJECT: assert property (@(posedge clk) rst |=> (sel_op_o && ir_o == BRK_OP)); // R1
  AST_OP_THEN_MICRO: assert property (@(posedge clk) disable iff (rst) sel_op_o |=> !sel_op_o); // R3
  AST_OP_ADDR: assert property (@(posedge clk) disable iff (rst) sel_op_o |-> (ucode_addr_o == {ir_o, {STEP_W{1'b0}}} && !mem_rd_o)); // R3
  AST_END_FETCH: assert property (@(posedge clk) disable iff (rst) mem_rd_o |=> (sel_op_o && ir_o == $past(mem_data_i))); // R5
  AST_IR_HELD: assert property (@(posedge clk) disable iff (rst) !mem_rd_o |=> $stable(ir_o)); // R6
  AST_RUN_CAP: assert property (@(posedge clk) disable iff (rst) !sel_op_o |-> run_q < RUN_LIM); // R7
endmodule

bind ucode_fetch_seq ucode_fetch_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_data_i   (mem_data_i),
  .ucode_addr_o (ucode_addr_o),
  .mem_rd_o     (mem_rd_o),
  .ir_o         (ir_o),
  .sel_op_o     (sel_op_o)
);

// File: tb/ucode_fetch_seq_tb.sv
module ucode_fetch_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_data = 8'hA5;
  logic [15:0] ucode_data;
  logic [10:0] ucode_addr;
  logic        mem_rd;
  logic [7:0]  ir;
  logic [15:0] mir;
  logic        sel_op;
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  // microcode length per opcode: opcodes >= F0 carry no end marker (8 words)
  function automatic int tb_len(input logic [7:0] op);
    return (op >= 8'hF0) ? 8 : (int'(op) % 7) + 1;
  endfunction

  function automatic logic [15:0] tb_word(input logic [10:0] a);
    logic [7:0] op = a[10:3];
    logic [2:0] s  = a[2:0];
    logic       e  = (op < 8'hF0) && (int'(s) == tb_len(op) - 1);
    return {op, 1'b0, s, 3'b101, e};
  endfunction

  assign ucode_data = tb_word(ucode_addr);

  ucode_fetch_seq u_dut (
    .clk          (clk),
    .rst          (rst),
    .mem_data_i   (mem_data),
    .ucode_data_i (ucode_data),
    .ucode_addr_o (ucode_addr),
    .mem_rd_o     (mem_rd),
    .ir_o         (ir),
    .mir_o        (mir),
    .sel_op_o     (sel_op)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      summary();
    end
  end

  // hold reset for two edges, check, release and check the injected state
  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(ucode_addr == 0, "R2 addr in reset", 32'(ucode_addr), 0);
    chk(!mem_rd, "R2 no read in reset", 32'(mem_rd), 0);
    chk(sel_op && ir == 8'h00, "R1 held reset state", {23'b0, sel_op, ir}, 32'h100);
    rst = 1'b0;
    #1;
    chk(sel_op, "R1 opcode phase", 32'(sel_op), 1);
    chk(ir == 8'h00, "R1 break opcode", 32'(ir), 0);
    chk(mir == 16'h0, "R1 mir cleared", 32'(mir), 0);
    chk(!mem_rd, "R2 no memory read on injection", 32'(mem_rd), 0);
  endtask

  // run one instruction starting at its opcode cycle; stop_after < 0 runs to end
  task automatic run_instr(input logic [7:0] op, input logic [7:0] nxt, input int stop_after);
    int n = tb_len(op);
    chk(sel_op, "R3 opcode cycle", 32'(sel_op), 1);
    chk(ir == op, "R6 ir holds opcode", 32'(ir), 32'(op));
    chk(ucode_addr == {op, 3'b000}, "R3 step zero address", 32'(ucode_addr), 32'({op, 3'b000}));
    chk(!mem_rd, "R3 no read on opcode cycle", 32'(mem_rd), 0);
    mem_data = ~op;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k == stop_after) return;
      chk(!sel_op, "R4 micro cycle", 32'(sel_op), 0);
      chk(mir == tb_word({op, 3'(k)}), "R4 micro word", 32'(mir), 32'(tb_word({op, 3'(k)})));
      chk(ir == op, "R6 ir stable in micro", 32'(ir), 32'(op));
      if (k == n - 1) begin
        chk(mem_rd, "R5 end reads memory", 32'(mem_rd), 1);
        if (op >= 8'hF0)
          chk(k == 7 && !mir[0], "R7 forced end at last slot", 32'(k), 7);
        mem_data = nxt;
      end else begin
        chk(!mem_rd, "R5 no read before end", 32'(mem_rd), 0);
        mem_data = 8'h5A ^ 8'(k);
      end
      @(negedge clk);
    end
    chk(sel_op && ir == nxt, "R5 next opcode loaded", {23'b0, sel_op, ir}, {23'b0, 1'b1, nxt});
  endtask

  initial begin
    t_reset();
    run_instr(8'h00, 8'h05, -1);
    run_instr(8'h05, 8'hF3, -1);
    run_instr(8'hF3, 8'h07, -1);
    // R8: single-word instructions back to back
    run_instr(8'h07, 8'h0E, -1);
    run_instr(8'h0E, 8'h00, -1);
    run_instr(8'h00, 8'h06, -1);
    run_instr(8'h06, 8'hFF, -1);
    run_instr(8'hFF, 8'h05, -1);
    // reset in the middle of an instruction returns to the break opcode
    run_instr(8'h05, 8'h00, 3);
    t_reset();
    run_instr(8'h00, 8'h0D, -1);
    run_instr(8'h0D, 8'h00, -1);
    summary();
  end
endmodule